// File: doc/BRIEF.md
# Debug Data Transfer Scan Chain

This block is a 34-bit debug scan chain that holds two single-word mailboxes between an external debugger and a processor core. The receive mailbox carries a word from the debugger to the core. The transmit mailbox carries a word from the core to the debugger. The debugger sees a single scanned register. The transmit word and two status bits are sampled into it at capture. Under the write-style instruction, the scanned-in word is offered to the receive mailbox at update.

The core writes the transmit mailbox through its own write port and reads the receive mailbox through a read port. It also supplies an execute-enable mode bit and an instruction-completion flag. The block enforces overwrite protection on the receive mailbox, using a flag sampled at the previous capture. In normal mode that flag is the receive-empty state. In execute mode it is the completion flag.

The TAP controller is outside this block; it supplies single-cycle capture, shift and update strobes that are synchronous to `clk`. The reset is asserted asynchronously and released synchronously inside the block.

Top module: `dtr_scan_chain`

## Requirements
- R1: After reset, `tdo_o`=0, `tx_full_o`=0, `rx_valid_o`=0 and `rx_data_o`=0.
- R2: A capture strobe with the chain selected loads the scan register as follows. Bit 0 is the transmit-full flag under INTEST (`ext_mode_i`=0) or the receive-empty flag under EXTEST (`ext_mode_i`=1). Bit 1 is `inst_done_i`. Bits 33:2 are the transmit word, under either instruction. `tdo_o` shows bit 0 one cycle after the strobe.
- R3: Each shift strobe with the chain selected moves the register one place toward bit 0 and takes `tdi_i` into bit 33; `tdo_o` always shows bit 0.
- R4: A core write sets transmit-full and stores the word. A write while transmit-full is already set replaces the word and leaves the flag set.
- R5: Transmit-full clears at a capture only under INTEST. It is unchanged by an EXTEST capture. A core write in the same cycle as an INTEST capture leaves it set.
- R6: An update strobe under EXTEST, with the chain selected and the load allowed, copies scan bits 33:2 into the receive word and sets `rx_valid_o` one cycle later.
- R7: With `exec_en_i`=0, the update is blocked and the receive word is kept if bit 0 was captured as 0 (the receive mailbox was full). Captured flags are 0 after reset.
- R8: With `exec_en_i`=1, the update is allowed exactly when bit 1 (completion) was captured as 1, whatever the receive-empty state.
- R9: A core read clears `rx_valid_o`. An allowed debugger update in the same cycle wins and leaves it set.
- R10: An update under INTEST changes neither mailbox. Strobes with `sel_i`=0 change neither the scan register nor the flags.
- R11: Changing `exec_en_i` alone alters no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | This chain is the selected scan chain |
| ext_mode_i | input | 1 | 1 = EXTEST, 0 = INTEST |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe |
| update_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (scan bit 0) |
| core_wr_i | input | 1 | Core write to transmit mailbox |
| core_wdata_i | input | 32 | Core write word |
| core_rd_i | input | 1 | Core read of receive mailbox |
| exec_en_i | input | 1 | Execute-enable mode bit |
| inst_done_i | input | 1 | Instruction completion flag |
| tx_full_o | output | 1 | Transmit mailbox holds an unread word |
| rx_valid_o | output | 1 | Receive mailbox holds an unread word |
| rx_data_o | output | 32 | Receive mailbox word |

## Verification
Each result is registered once, so every output reflects a strobe or core access in the cycle after the clock edge that samples it. For example, `tdo_o` shows captured bit 0 one cycle after capture, and `rx_valid_o` and `rx_data_o` move one cycle after update or read. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge, and all four outputs are compared against it on every falling edge, so each comparison sees the state one edge after the stimulus. Directed checks read the serial bits on the falling edge before each shift, so captured flags and words are checked exactly where they appear.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STAT_W = 2;
  localparam int unsigned CHAIN_W = DATA_W + STAT_W;
  localparam int unsigned BIT_STAT = 0;
  localparam int unsigned BIT_RDY = 1;
endpackage

// File: rtl/dtr_rst_sync.sv
module dtr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else if (g == 0) stage_q[g] <= 1'b1;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/dtr_shift_reg.sv
module dtr_shift_reg #(
  parameter int unsigned W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] par
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (cap_en) sr_d = cap_val;
    else if (shift_en) sr_d = {sin, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (cap_en || shift_en) sr_q <= sr_d;
  end

  assign par = sr_q;
endmodule

// File: rtl/dtr_tx_buf.sv
module dtr_tx_buf #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         clr_en,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q, full_d;
  logic [W-1:0] data_q;

  always_comb begin
    full_d = full_q;
    if (clr_en) full_d = 1'b0;
    if (wr_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (wr_en) data_q <= wdata;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/dtr_rx_buf.sv
module dtr_rx_buf #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  input  logic         rd_en,
  output logic         empty,
  output logic [W-1:0] data
);
  logic         empty_q, empty_d;
  logic [W-1:0] data_q;

  always_comb begin
    empty_d = empty_q;
    if (rd_en) empty_d = 1'b1;
    if (load_en) empty_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      data_q  <= '0;
    end else begin
      empty_q <= empty_d;
      if (load_en) data_q <= load_data;
    end
  end

  assign empty = empty_q;
  assign data  = data_q;
endmodule

// File: rtl/dtr_scan_chain.sv
module dtr_scan_chain
  import dtr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              ext_mode_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              core_wr_i,
  input  logic [DATA_W-1:0] core_wdata_i,
  input  logic              core_rd_i,
  input  logic              exec_en_i,
  input  logic              inst_done_i,
  output logic              tx_full_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic               rst_s_n;
  logic               cap_fire, shift_fire, upd_fire;
  logic               tx_full, rx_empty;
  logic [DATA_W-1:0]  tx_data, rx_data;
  logic [CHAIN_W-1:0] cap_val, sr;
  logic               cap_nretry_q, cap_ready_q;
  logic               cap_nretry_d, cap_ready_d;
  logic               load_ok, rx_load, tx_clr;

  dtr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  assign cap_fire   = sel_i & capture_i;
  assign shift_fire = sel_i & shift_i & ~capture_i;
  assign upd_fire   = sel_i & update_i;

  always_comb begin
    cap_val                = '0;
    cap_val[CHAIN_W-1:STAT_W] = tx_data;
    cap_val[BIT_RDY]       = inst_done_i;
    cap_val[BIT_STAT]      = ext_mode_i ? rx_empty : tx_full;
  end

  always_comb begin
    cap_nretry_d = cap_nretry_q;
    cap_ready_d  = cap_ready_q;
    if (cap_fire) begin
      cap_nretry_d = rx_empty;
      cap_ready_d  = inst_done_i;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cap_nretry_q <= 1'b0;
      cap_ready_q  <= 1'b0;
    end else if (cap_fire) begin
      cap_nretry_q <= cap_nretry_d;
      cap_ready_q  <= cap_ready_d;
    end
  end

  assign load_ok = exec_en_i ? cap_ready_q : cap_nretry_q;
  assign rx_load = upd_fire & ext_mode_i & load_ok;
  assign tx_clr  = cap_fire & ~ext_mode_i;

  dtr_shift_reg #(.W(CHAIN_W)) u_sr (
    .clk(clk), .rst_n(rst_s_n), .cap_en(cap_fire), .cap_val(cap_val),
    .shift_en(shift_fire), .sin(tdi_i), .par(sr)
  );

  dtr_tx_buf #(.W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .wr_en(core_wr_i), .wdata(core_wdata_i),
    .clr_en(tx_clr), .full(tx_full), .data(tx_data)
  );

  dtr_rx_buf #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .load_en(rx_load),
    .load_data(sr[CHAIN_W-1:STAT_W]), .rd_en(core_rd_i),
    .empty(rx_empty), .data(rx_data)
  );

  assign tdo_o      = sr[0];
  assign tx_full_o  = tx_full;
  assign rx_valid_o = ~rx_empty;
  assign rx_data_o  = rx_data;
endmodule

// File: rtl/dtr_scan_chain_chk.sv
module dtr_scan_chain_chk
  import dtr_pkg::*;
(
  input logic               clk,
  input logic               rst_s_n,
  input logic               sel_i,
  input logic               ext_mode_i,
  input logic               capture_i,
  input logic               shift_i,
  input logic               update_i,
  input logic               core_wr_i,
  input logic               core_rd_i,
  input logic               exec_en_i,
  input logic               tdo_o,
  input logic               tx_full_o,
  input logic               rx_valid_o,
  input logic [DATA_W-1:0]  rx_data_o,
  input logic               cap_nretry_q,
  input logic               cap_ready_q,
  input logic [CHAIN_W-1:0] sr
);
  // R4
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    core_wr_i |=> tx_full_o);
  // R5
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_i && capture_i && !ext_mode_i && !core_wr_i) |=> !tx_full_o);
  // R5
  tx_keep_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_i && capture_i && ext_mode_i && tx_full_o) |=> tx_full_o);
  // R3
  shift_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_i && shift_i && !capture_i) |=> (tdo_o == $past(sr[1])));
  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_i && update_i && ext_mode_i && (exec_en_i ? cap_ready_q : cap_nretry_q))
    |=> (rx_valid_o && rx_data_o == $past(sr[CHAIN_W-1:STAT_W])));
  // R7
  nretry_block_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_i && update_i && !exec_en_i && !cap_nretry_q) |=> $stable(rx_data_o));
  // R8
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel_i && update_i && exec_en_i && !cap_ready_q) |=> $stable(rx_data_o));
  // R9
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (core_rd_i && !(sel_i && update_i && ext_mode_i)) |=> !rx_valid_o);
  // R10
  unsel_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!sel_i && !core_wr_i && !core_rd_i) |=> ($stable(tdo_o) && $stable(tx_full_o) && $stable(rx_valid_o)));
endmodule

bind dtr_scan_chain dtr_scan_chain_chk u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .sel_i(sel_i), .ext_mode_i(ext_mode_i),
  .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
  .core_wr_i(core_wr_i), .core_rd_i(core_rd_i), .exec_en_i(exec_en_i),
  .tdo_o(tdo_o), .tx_full_o(tx_full_o), .rx_valid_o(rx_valid_o),
  .rx_data_o(rx_data_o), .cap_nretry_q(cap_nretry_q),
  .cap_ready_q(cap_ready_q), .sr(sr)
);

// File: tb/dtr_scan_chain_tb.sv
module dtr_scan_chain_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, ext = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic        core_wr = 1'b0, core_rd = 1'b0, exec_en = 1'b0, inst_done = 1'b1;
  logic [31:0] wdata = '0;
  logic        tdo, tx_full, rx_valid;
  logic [31:0] rx_data;

  int total = 0;
  int bad = 0;

  dtr_scan_chain u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .ext_mode_i(ext),
    .capture_i(cap), .shift_i(sh), .update_i(upd), .tdi_i(tdi), .tdo_o(tdo),
    .core_wr_i(core_wr), .core_wdata_i(wdata), .core_rd_i(core_rd),
    .exec_en_i(exec_en), .inst_done_i(inst_done), .tx_full_o(tx_full),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_q[$];
  bit          m_txf, m_rxe, m_nretry, m_ready;
  logic [31:0] m_txd, m_rxd;
  bit          m_live = 0;

  task automatic m_reset();
    m_q.delete();
    for (int i = 0; i < 34; i++) m_q.push_back(1'b0);
    m_txf = 0; m_rxe = 1; m_nretry = 0; m_ready = 0; m_txd = '0; m_rxd = '0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n || !m_live) m_reset();
    else begin
      bit          n_txf, n_rxe;
      logic [31:0] n_txd, n_rxd;
      bit          ok;
      n_txf = m_txf; n_rxe = m_rxe; n_txd = m_txd; n_rxd = m_rxd;
      ok = exec_en ? m_ready : m_nretry;
      if (sel && upd && ext && ok) begin
        for (int i = 0; i < 32; i++) n_rxd[i] = m_q[i+2];
      end
      if (core_rd) n_rxe = 1;
      if (sel && upd && ext && ok) n_rxe = 0;
      if (sel && cap) begin
        m_q.delete();
        m_q.push_back(ext ? m_rxe : m_txf);
        m_q.push_back(inst_done);
        for (int i = 0; i < 32; i++) m_q.push_back(m_txd[i]);
        m_nretry = m_rxe; m_ready = inst_done;
        if (!ext) n_txf = 0;
      end else if (sel && sh) begin
        void'(m_q.pop_front());
        m_q.push_back(tdi);
      end
      if (core_wr) begin n_txf = 1; n_txd = wdata; end
      m_txf = n_txf; m_rxe = n_rxe; m_txd = n_txd; m_rxd = n_rxd;
    end
  end

  always @(negedge clk) begin
    if (m_live) begin
      chk("R3 tdo", 64'(tdo), 64'(m_q[0]));
      chk("R5 tx_full", 64'(tx_full), 64'(m_txf));
      chk("R6 rx_valid", 64'(rx_valid), 64'(!m_rxe));
      chk("R6 rx_data", 64'(rx_data), 64'(m_rxd));
    end
  end

  // stimulus tasks: each starts and ends just after a falling edge
  task automatic core_write(input logic [31:0] d);
    core_wr = 1; wdata = d; @(negedge clk); core_wr = 0;
  endtask

  task automatic core_read();
    core_rd = 1; @(negedge clk); core_rd = 0;
  endtask

  task automatic scan(input bit e, input logic [31:0] d, output logic [33:0] o);
    logic [33:0] din;
    din = {d, 2'b00};
    sel = 1; ext = e; cap = 1; @(negedge clk); cap = 0;
    for (int i = 0; i < 34; i++) begin
      o[i] = tdo; sh = 1; tdi = din[i]; @(negedge clk);
    end
    sh = 0; upd = 1; @(negedge clk); upd = 0; sel = 0;
  endtask

  initial begin
    logic [33:0] o;
    #(CLK_PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [33:0] o;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_live = 1;
    // R1
    chk("R1 tdo", 64'(tdo), 0);
    chk("R1 tx_full", 64'(tx_full), 0);
    chk("R1 rx_valid", 64'(rx_valid), 0);
    chk("R1 rx_data", 64'(rx_data), 0);

    // R2 R5: INTEST capture of transmit word, flag clears
    core_write(32'hA5A5_0001);
    chk("R4 set", 64'(tx_full), 1);
    scan(0, 32'h0, o);
    chk("R2 bit0 txfull", 64'(o[0]), 1);
    chk("R2 bit1 ready", 64'(o[1]), 1);
    chk("R2 data", 64'(o[33:2]), 64'(32'hA5A5_0001));
    chk("R5 intest clr", 64'(tx_full), 0);
    chk("R10 intest upd", 64'(rx_valid), 0);

    // R4 overwrite, R5 EXTEST keeps, R6 load
    core_write(32'h1111_2222);
    core_write(32'h3333_4444);
    chk("R4 still full", 64'(tx_full), 1);
    scan(1, 32'hDEAD_BEEF, o);
    chk("R2 bit0 rxempty", 64'(o[0]), 1);
    chk("R4 overwrite data", 64'(o[33:2]), 64'(32'h3333_4444));
    chk("R5 extest keep", 64'(tx_full), 1);
    chk("R6 rx loaded", 64'(rx_data), 64'(32'hDEAD_BEEF));
    chk("R6 rx valid", 64'(rx_valid), 1);

    // R7: receive full, nRetry captured 0, blocked
    scan(1, 32'h0BAD_0BAD, o);
    chk("R7 nretry0", 64'(o[0]), 0);
    chk("R7 blocked", 64'(rx_data), 64'(32'hDEAD_BEEF));

    // R9 core read
    core_read();
    chk("R9 read clr", 64'(rx_valid), 0);

    // R11 exec toggle
    exec_en = 1; @(negedge clk);
    chk("R11 tx", 64'(tx_full), 1);
    chk("R11 rx", 64'(rx_valid), 0);

    // R8: exec mode, completion captured 0 blocks
    inst_done = 0;
    scan(1, 32'h5555_AAAA, o);
    chk("R8 ready0", 64'(o[1]), 0);
    chk("R8 blocked", 64'(rx_valid), 0);
    inst_done = 1;
    scan(1, 32'h1234_5678, o);
    chk("R8 loaded", 64'(rx_data), 64'(32'h1234_5678));
    scan(1, 32'h8765_4321, o);
    chk("R8 full ok", 64'(o[0]), 0);
    chk("R8 overwrite", 64'(rx_data), 64'(32'h8765_4321));
    exec_en = 0; @(negedge clk);
    chk("R11 rx back", 64'(rx_valid), 1);

    // R10 unselected strobes
    cap = 1; sh = 1; upd = 1; ext = 0; tdi = 1; @(negedge clk);
    cap = 0; sh = 0; upd = 0;
    repeat (3) begin sh = 1; @(negedge clk); end
    sh = 0;
    chk("R10 unsel tx", 64'(tx_full), 1);
    chk("R10 unsel rx", 64'(rx_data), 64'(32'h8765_4321));

    // R5 same-cycle write with INTEST capture
    sel = 1; ext = 0; cap = 1; core_wr = 1; wdata = 32'hCAFE_F00D;
    @(negedge clk); cap = 0; core_wr = 0; sel = 0;
    chk("R5 write wins", 64'(tx_full), 1);

    // R9 same-cycle read and allowed update (exec=1, ready captured 1)
    exec_en = 1;
    sel = 1; ext = 1; cap = 1; @(negedge clk); cap = 0;
    upd = 1; core_rd = 1; @(negedge clk); upd = 0; core_rd = 0; sel = 0;
    chk("R9 update wins", 64'(rx_valid), 1);
    core_read();
    chk("R9 final read", 64'(rx_valid), 0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule